// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Vectoring

This block collects interrupt requests and decides which one the processor services next. Three sources have a fixed rank that software cannot change. These are the post-reset start request, the non-maskable interrupt and the watchdog. Every other source is maskable. Each maskable source has a small control register that holds a software-chosen priority level and a pending-request flag.

A maskable request competes only when its level is above the processor's current interrupt level. The winner's vector address is always present on the output. When the processor acknowledges, the block reports the accepted vector and level for one cycle. It clears the accepted source's pending flag at the same clock edge.

Vectors are 16-bit entries in the top page of the address map. Maskable source `i` uses `0x00FFC0 + 2*i`. Two slots in that page are reserved for debug and break traps, and the arbiter never hands them out.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, every request flag and every level reads 0. A start request is pending, so `irq` is 1 and `irq_vec` is 0x00FFFE until that request is acknowledged.
- R2: Fixed ranking applies regardless of `cpu_ipl`. The start request comes first, then the non-maskable request (vector 0x00FFFA), then the watchdog (vector 0x00FFF8), and then any maskable source.
- R3: The control register of source `i` is at `reg_addr = i`. Bits [2:0] hold the level and bit 3 holds the request flag. Bits [7:4] read 0 and writes to them are ignored. `reg_rdata` shows the addressed register in the same cycle.
- R4: A maskable source competes only if its request flag is 1 and its level is strictly greater than `cpu_ipl`. A source at level 0 never wins.
- R5: Among competing maskable sources, the highest level wins. A tie goes to the higher source index, which has the higher vector. The vector of source `i` is 0x00FFC0 + 2*i.
- R6: `ack` while `irq` is 1 has two effects in the next cycle. First, `ack_valid` is 1 for one cycle, with `ack_vec` equal to the accepted vector and `ack_lvl` equal to its level (7 for the fixed-rank sources). Second, the accepted source's pending flag is cleared at that edge.
- R7: The non-maskable and watchdog requests stay pending until they are accepted. No register write clears them.
- R8: A register write sets or clears the request flag through bit 3. A hardware pulse on `src_req[i]` in the same cycle leaves the flag set, even against a clearing write or an acceptance.
- R9: The reserved vectors 0x00FFF4 and 0x00FFF6 never appear on `irq_vec`.
- R10: `ack` while `irq` is 0 leaves `ack_valid` at 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | One-cycle request pulses from maskable sources |
| nmi_req | input | 1 | Non-maskable request pulse |
| wdt_req | input | 1 | Watchdog request pulse |
| cpu_ipl | input | 3 | Processor's current interrupt level |
| ack | input | 1 | Processor accepts the present winner |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | AW | Control register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Addressed control register |
| irq | output | 1 | A winner exists |
| irq_vec | output | 24 | Vector address of the present winner |
| ack_valid | output | 1 | One-cycle pulse after an acceptance |
| ack_vec | output | 24 | Accepted vector address |
| ack_lvl | output | 3 | Accepted level |

## Verification
The hardest situation to reach is a single edge where several things hit the same request flag at once: a hardware pulse, a clearing register write and an acceptance. Another is a pending non-maskable request that survives writes which clear every register. The bench drives these collisions on purpose. It also runs a long stretch of random pulses, writes, acknowledges and level changes. A behavioural model checks every output on every cycle, which covers ties and level-boundary comparisons against `cpu_ipl` that directed cases would miss.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 8,
  parameter int AW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            nmi_req,
  input  logic            wdt_req,
  input  logic [2:0]      cpu_ipl,
  input  logic            ack,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            irq,
  output logic [23:0]     irq_vec,
  output logic            ack_valid,
  output logic [23:0]     ack_vec,
  output logic [2:0]      ack_lvl
);
  localparam logic [23:0] VEC_RST  = 24'h00FFFE;
  localparam logic [23:0] VEC_NMI  = 24'h00FFFA;
  localparam logic [23:0] VEC_WDT  = 24'h00FFF8;
  localparam logic [23:0] VEC_DBG  = 24'h00FFF6;
  localparam logic [23:0] VEC_BRK  = 24'h00FFF4;
  localparam logic [23:0] VEC_BASE = 24'h00FFC0;

  logic [2:0]      lvl [NSRC];
  logic [NSRC-1:0] req;
  logic            rst_pend, nmi_pend, wdt_pend;
  logic            m_hit;
  logic [AW-1:0]   m_idx;
  logic [2:0]      m_lvl;

  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    m_lvl = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i] && lvl[i] > cpu_ipl && (!m_hit || lvl[i] >= m_lvl)) begin
        m_hit = 1'b1;
        m_idx = AW'(i);
        m_lvl = lvl[i];
      end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == AW'(i)) reg_rdata = {4'b0, req[i], lvl[i]};
  end

  wire       fixed   = rst_pend | nmi_pend | wdt_pend;
  wire [2:0] win_lvl = fixed ? 3'd7 : m_lvl;
  wire       take    = ack & irq;
  wire       take_m  = take & ~fixed;

  assign irq     = fixed | m_hit;
  assign irq_vec = rst_pend ? VEC_RST :
                   nmi_pend ? VEC_NMI :
                   wdt_pend ? VEC_WDT :
                   VEC_BASE + 24'({m_idx, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend  <= 1'b1;
      nmi_pend  <= 1'b0;
      wdt_pend  <= 1'b0;
      req       <= '0;
      ack_valid <= 1'b0;
      ack_vec   <= '0;
      ack_lvl   <= '0;
      for (int i = 0; i < NSRC; i++) lvl[i] <= '0;
    end else begin
      ack_valid <= take;
      if (take) begin
        ack_vec <= irq_vec;
        ack_lvl <= win_lvl;
      end
      if (take) rst_pend <= 1'b0;
      nmi_pend <= (nmi_pend & ~(take & ~rst_pend)) | nmi_req;
      wdt_pend <= (wdt_pend & ~(take & ~rst_pend & ~nmi_pend)) | wdt_req;
      for (int i = 0; i < NSRC; i++) begin
        if (reg_we && reg_addr == AW'(i)) lvl[i] <= reg_wdata[2:0];
        req[i] <= (((reg_we && reg_addr == AW'(i)) ? reg_wdata[3] : req[i])
                   & ~(take_m && m_idx == AW'(i))) | src_req[i];
      end
    end
  end

  p_ack_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq |=> ack_valid && ack_vec == $past(irq_vec) && ack_lvl == $past(win_lvl));
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq && !fixed && !src_req[m_idx] |=> !req[$past(m_idx)]);
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq) |=> !ack_valid);
  p_above_ipl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !fixed |-> m_lvl > cpu_ipl && req[m_idx]);
  p_fixed_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && !rst_pend |-> irq && irq_vec == VEC_NMI);
  p_no_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_vec != VEC_BRK && irq_vec != VEC_DBG);
  p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && !ack |=> nmi_pend);
endmodule

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_req = '0;
  logic nmi_req = 0, wdt_req = 0, ack = 0, reg_we = 0;
  logic [2:0] cpu_ipl = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq, ack_valid;
  logic [23:0] irq_vec, ack_vec;
  logic [2:0] ack_lvl;

  irq_arbiter #(.NSRC(N)) u_irq_arbiter (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit started = 0;

  int  m_lvl [N];
  bit  m_req [N];
  bit  m_rst, m_nmi, m_wdt, m_av;
  int  m_avec, m_alvl;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void winner(output bit any, output int vec, output int lv, output int idx);
    any = 1; idx = -1; lv = 7;
    if (m_rst) vec = 'hFFFE;
    else if (m_nmi) vec = 'hFFFA;
    else if (m_wdt) vec = 'hFFF8;
    else begin
      any = 0; vec = 0; lv = 0;
      for (int i = N - 1; i >= 0; i--)
        if (m_req[i] && m_lvl[i] > int'(cpu_ipl) && (!any || m_lvl[i] > lv)) begin
          any = 1; idx = i; lv = m_lvl[i]; vec = 'hFFC0 + 2 * i;
        end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_req[i] = 0; end
      m_rst = 1; m_nmi = 0; m_wdt = 0; m_av = 0; m_avec = 0; m_alvl = 0;
    end else begin
      bit any; int vec, lv, idx;
      winner(any, vec, lv, idx);
      m_av = ack && any;
      if (m_av) begin m_avec = vec; m_alvl = lv; end
      if (m_av) begin
        if (m_rst) m_rst = 0;
        else if (m_nmi) m_nmi = 0;
        else if (m_wdt) m_wdt = 0;
      end
      if (nmi_req) m_nmi = 1;
      if (wdt_req) m_wdt = 1;
      for (int i = 0; i < N; i++) begin
        if (reg_we && int'(reg_addr) == i) begin
          m_lvl[i] = reg_wdata[2:0];
          m_req[i] = reg_wdata[3];
        end
        if (m_av && idx == i) m_req[i] = 0;
        if (src_req[i]) m_req[i] = 1;
      end
    end
  end

  always @(negedge clk) if (started) begin
    bit any; int vec, lv, idx, a;
    winner(any, vec, lv, idx);
    a = int'(reg_addr);
    chk("irq", int'(irq), int'(any));
    if (any) chk("irq_vec", int'(irq_vec), vec);
    chk("reg_rdata", int'(reg_rdata), (int'(m_req[a]) << 3) | m_lvl[a]);
    chk("ack_valid", int'(ack_valid), int'(m_av));
    if (m_av) begin
      chk("ack_vec", int'(ack_vec), m_avec);
      chk("ack_lvl", int'(ack_lvl), m_alvl);
    end
    if (irq) begin
      tag = "R9";
      chk("reserved vector", int'(irq_vec == 24'hFFF4 || irq_vec == 24'hFFF6), 0);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
    src_req = '0; nmi_req = 0; wdt_req = 0; ack = 0; reg_we = 0;
  endtask

  task automatic wr(int a, int lv, int rq);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = 8'(lv | (rq << 3)); tick();
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    #5 started = 1;
    #30;
    tag = "R1"; reg_addr = 5;
    @(negedge clk);
    chk("reset irq", int'(irq), 1);
    chk("reset vec", int'(irq_vec), 'hFFFE);
    #2 rst_n = 1;
    tick(2);
    tag = "R10"; tick(1);
    tag = "R6"; ack = 1; tick(1); tick(1);
    tag = "R10"; ack = 1; tick(1); tick(1);
    tag = "R3";
    for (int i = 0; i < N; i++) wr(i, i % 8, 0);
    reg_we = 1; reg_addr = 2; reg_wdata = 8'hF3; tick();
    reg_addr = 2; tick();
    tag = "R4"; cpu_ipl = 2;
    src_req[2] = 1; tick(); tick();
    cpu_ipl = 3; tick();
    src_req[0] = 1; cpu_ipl = 0; tick(); tick();
    wr(0, 0, 0); wr(2, 3, 0);
    tag = "R5";
    wr(1, 4, 0); wr(5, 4, 0); cpu_ipl = 1;
    src_req[1] = 1; src_req[5] = 1; tick(); tick();
    ack = 1; tick(); tick();
    src_req[6] = 1; wr(6, 6, 0); src_req[6] = 1; tick(); tick();
    tag = "R2"; cpu_ipl = 7;
    wdt_req = 1; nmi_req = 1; tick(); tick();
    tag = "R7";
    for (int i = 0; i < N; i++) wr(i, 0, 0);
    tick();
    tag = "R6"; ack = 1; tick(); ack = 1; tick(); tick();
    tag = "R8"; cpu_ipl = 0;
    wr(3, 5, 1); tick();
    src_req[3] = 1; reg_we = 1; reg_addr = 3; reg_wdata = 8'h05; tick(); tick();
    src_req[3] = 1; ack = 1; tick(); tick();
    wr(3, 5, 0); tick();
    tag = "R5";
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 100;
      src_req = N'($urandom) & N'($urandom);
      nmi_req = ($urandom % 40) == 0;
      wdt_req = ($urandom % 40) == 0;
      ack = ($urandom % 3) == 0;
      reg_addr = 3'($urandom);
      if (r < 25) begin reg_we = 1; reg_wdata = 8'($urandom); end
      if (r > 90) cpu_ipl = 3'($urandom);
      @(posedge clk); #2;
      src_req = '0; nmi_req = 0; wdt_req = 0; ack = 0; reg_we = 0;
    end
    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule